// File: doc/BRIEF.md
# Colour Lookup Host Register Interface

This block is the host-facing control of a colour-lookup device. A host selects one of eight access modes with a 3-bit selector and a read/write flag. Both are taken at the cycle in which the active-low chip enable is first seen low. Each falling edge of chip enable makes exactly one access. The block keeps a 13-bit palette address that steps on its own, a command register, a status view of the external write queue, and a revision register. The revision register combines a fixed design revision with a board-revision input.

Palette data moves one byte at a time through a modulo-3 sequencer that visits red, then green, then blue. On a write, red and green are parked in buffer registers. The blue byte then sends the address and the full 24-bit colour to an external write queue as a one-cycle push, and the address steps by one. On a read, bytes are taken from the external lookup-table read port at the current address, and the address steps after blue. If a host stops part way through a colour write, it can get its red and green bytes back: it resets the sequencer with an address write, then reads the colour buffer twice. A palette-read window flag is opened and closed by the host, so that external logic can give the lookup tables to the host.

Top module: `lutHostPort`

## Requirements
- R1: The mode and the read/write flag (1 = read, 0 = write) are taken in the clock cycle where chip enable is first seen low after being high. Holding chip enable low performs no further access until it goes high and low again.
- R2: Mode 0 writes/reads address bits 7:0. Mode 1 writes address bits 12:8 from bus bits 4:0 and ignores bus bits 7:5. Reads of mode 1 return zero in bits 7:5.
- R3: The sequencer counts 0 (red), 1 (green), 2 (blue). Any write of mode 0 or mode 1 returns it to 0. Its value is visible in status bits 1:0.
- R4: Writes of mode 2 at count 0 and count 1 store red and green and advance the count. A write at count 2 pulses queue push for one cycle with the current address and colour {blue, green, red} (red in bits 7:0, green in 15:8, blue in 23:16). It then clears the count and increments the address modulo 8192.
- R5: Reads of mode 2 return byte 0, 1 or 2 of the lookup read data at the current address for count 0, 1 or 2. Red and green advance the count. Blue clears it and increments the address.
- R6: Reads of mode 5 return the red buffer at count 0 and advance the count to 1. At count 1 they return the green buffer and leave the count alone. At count 2 they return zero and leave the count alone.
- R7: Reads of mode 4 return the count in bits 1:0, the queue empty, level and full flags (active low, passed through as given) in bits 2, 3 and 4, and zero in bits 7:5.
- R8: Reads of mode 6 return the fixed revision (default 5) in bits 2:0, zero in bit 3 and the board-revision input in bits 7:4.
- R9: Writes of mode 3 load the command register, which is driven on `cmdReg` and returned by reads of mode 3.
- R10: Writes of modes 4, 5 and 6 change no register: address, count, command, buffers and palette-read flag all keep their values.
- R11: A write of mode 7 sets the palette-read flag. A read of mode 7 clears it and returns zero.
- R12: Read data is registered at the access and held until the next read. The bus-drive enable rises with a read access and falls in the cycle after chip enable is seen high. After reset, read data, push, flag, command and address are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Active-low chip enable; a falling edge starts one access |
| rdWr | input | 1 | 1 = read, 0 = write |
| modeSel | input | 3 | Access mode |
| busIn | input | 8 | Host write data |
| busOut | output | 8 | Host read data |
| busOe | output | 1 | Read-data drive enable |
| qPush | output | 1 | One-cycle push into the write queue |
| qAddr | output | 13 | Address pushed with the colour |
| qColor | output | 24 | Colour pushed {blue, green, red} |
| qEmptyN | input | 1 | Queue empty flag, active low |
| qLevelN | input | 1 | Queue half/almost-full flag, active low |
| qFullN | input | 1 | Queue full flag, active low |
| lutRdAddr | output | 13 | Current address register, used as lookup read address |
| lutRdData | input | 24 | Lookup read data {blue, green, red} at `lutRdAddr` |
| prdActive | output | 1 | Palette-read window flag |
| cmdReg | output | 8 | Command register contents |
| boardRev | input | 4 | Board revision bits |

## Verification
The checker takes two things for granted. First, chip enable is held high while reset is applied. Second, mode, flag and write data stay steady in the cycle where chip enable first reads low, so that the access seen one cycle later can be traced back to those port values. The bench drives every input at the falling clock edge. It raises chip enable between accesses and keeps it high through reset, so both conditions always hold. It also assumes the lookup read data follows the read address within the same cycle. The bench's lookup model is a pure function of that address.

// File: rtl/lutHostPkg.sv
package lutHostPkg;

  typedef enum logic [2:0] {
    MODE_ADDR_LO = 3'd0,
    MODE_ADDR_HI = 3'd1,
    MODE_PAL     = 3'd2,
    MODE_CMD     = 3'd3,
    MODE_STAT    = 3'd4,
    MODE_CBUF    = 3'd5,
    MODE_REV     = 3'd6,
    MODE_PRD     = 3'd7
  } hostMode_e;

  // strobes from control to datapath, valid for the accept cycle only
  typedef struct packed {
    logic      wrAddrLo;
    logic      wrAddrHi;
    logic      wrPal;
    logic      wrCmd;
    logic      prdStart;
    logic      prdStop;
    logic      rdEn;
    hostMode_e rdMode;
  } hostStb_t;

  localparam logic [1:0] SEQ_RED   = 2'd0;
  localparam logic [1:0] SEQ_GREEN = 2'd1;
  localparam logic [1:0] SEQ_BLUE  = 2'd2;

endpackage

// File: rtl/lutHostCtrl.sv
module lutHostCtrl
  import lutHostPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       rdWr,
  input  logic [2:0] modeSel,
  output hostStb_t   stb,
  output logic       busOe
);

  logic      ceDly;
  logic      accept;
  hostMode_e curMode;

  always_ff @(posedge clk) begin
    if (!rstN) ceDly <= 1'b1;
    else       ceDly <= ceN;
  end

  assign accept  = ceDly & ~ceN;
  assign curMode = hostMode_e'(modeSel);

  always_comb begin
    stb = '0;
    if (accept) begin
      if (rdWr) begin
        stb.rdEn   = 1'b1;
        stb.rdMode = curMode;
        if (curMode == MODE_PRD) stb.prdStop = 1'b1;
      end else begin
        unique case (curMode)
          MODE_ADDR_LO: stb.wrAddrLo = 1'b1;
          MODE_ADDR_HI: stb.wrAddrHi = 1'b1;
          MODE_PAL:     stb.wrPal    = 1'b1;
          MODE_CMD:     stb.wrCmd    = 1'b1;
          MODE_PRD:     stb.prdStart = 1'b1;
          default:      ;  // status, colour buffer, revision: no write effect
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)       busOe <= 1'b0;
    else if (ceN)    busOe <= 1'b0;
    else if (accept) busOe <= rdWr;
  end

endmodule

// File: rtl/lutHostData.sv
module lutHostData
  import lutHostPkg::*;
#(
  parameter int          ADDR_W = 13,
  parameter int          CH_W   = 8,
  parameter logic [2:0]  REV_ID = 3'd5,
  localparam int         HI_W   = ADDR_W - CH_W,
  localparam int         COL_W  = 3 * CH_W,
  localparam int         BRD_W  = CH_W - 4
)(
  input  logic              clk,
  input  logic              rstN,
  input  hostStb_t          stb,
  input  logic [CH_W-1:0]   busIn,
  input  logic              qEmptyN,
  input  logic              qLevelN,
  input  logic              qFullN,
  input  logic [COL_W-1:0]  lutRdData,
  input  logic [BRD_W-1:0]  boardRev,
  output logic [CH_W-1:0]   busOut,
  output logic              qPush,
  output logic [ADDR_W-1:0] qAddr,
  output logic [COL_W-1:0]  qColor,
  output logic [ADDR_W-1:0] addrReg,
  output logic              prdActive,
  output logic [CH_W-1:0]   cmdReg
);

  logic [1:0]      seqCnt;
  logic [CH_W-1:0] redBuf;
  logic [CH_W-1:0] greenBuf;
  logic [CH_W-1:0] palByte [3];
  logic [CH_W-1:0] rdVal;
  logic [CH_W-1:0] statVal;
  logic [CH_W-1:0] revVal;
  logic [CH_W-1:0] hiVal;
  logic [CH_W-1:0] palSel;
  logic [CH_W-1:0] bufSel;

  // split lookup read data into per-channel bytes
  for (genvar g = 0; g < 3; g++) begin : g_chan
    assign palByte[g] = lutRdData[g*CH_W +: CH_W];
  end

  always_comb begin
    statVal    = '0;
    statVal[1:0] = seqCnt;
    statVal[2] = qEmptyN;
    statVal[3] = qLevelN;
    statVal[4] = qFullN;
  end

  always_comb begin
    revVal = '0;
    revVal[2:0] = REV_ID;
    revVal[CH_W-1:4] = boardRev;
  end

  always_comb begin
    hiVal = '0;
    hiVal[HI_W-1:0] = addrReg[ADDR_W-1:CH_W];
  end

  always_comb begin
    case (seqCnt)
      SEQ_RED:   palSel = palByte[0];
      SEQ_GREEN: palSel = palByte[1];
      default:   palSel = palByte[2];
    endcase
    case (seqCnt)
      SEQ_RED:   bufSel = redBuf;
      SEQ_GREEN: bufSel = greenBuf;
      default:   bufSel = '0;
    endcase
  end

  always_comb begin
    unique case (stb.rdMode)
      MODE_ADDR_LO: rdVal = addrReg[CH_W-1:0];
      MODE_ADDR_HI: rdVal = hiVal;
      MODE_PAL:     rdVal = palSel;
      MODE_CMD:     rdVal = cmdReg;
      MODE_STAT:    rdVal = statVal;
      MODE_CBUF:    rdVal = bufSel;
      MODE_REV:     rdVal = revVal;
      default:      rdVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg   <= '0;
      seqCnt    <= SEQ_RED;
      redBuf    <= '0;
      greenBuf  <= '0;
      cmdReg    <= '0;
      prdActive <= 1'b0;
      busOut    <= '0;
      qPush     <= 1'b0;
      qAddr     <= '0;
      qColor    <= '0;
    end else begin
      qPush <= 1'b0;
      if (stb.wrAddrLo) begin
        addrReg[CH_W-1:0] <= busIn;
        seqCnt <= SEQ_RED;
      end
      if (stb.wrAddrHi) begin
        addrReg[ADDR_W-1:CH_W] <= busIn[HI_W-1:0];
        seqCnt <= SEQ_RED;
      end
      if (stb.wrPal) begin
        case (seqCnt)
          SEQ_RED: begin
            redBuf <= busIn;
            seqCnt <= SEQ_GREEN;
          end
          SEQ_GREEN: begin
            greenBuf <= busIn;
            seqCnt   <= SEQ_BLUE;
          end
          default: begin
            qPush   <= 1'b1;
            qAddr   <= addrReg;
            qColor  <= {busIn, greenBuf, redBuf};
            seqCnt  <= SEQ_RED;
            addrReg <= addrReg + 1'b1;
          end
        endcase
      end
      if (stb.wrCmd)    cmdReg    <= busIn;
      if (stb.prdStart) prdActive <= 1'b1;
      if (stb.prdStop)  prdActive <= 1'b0;
      if (stb.rdEn) begin
        busOut <= rdVal;
        if (stb.rdMode == MODE_PAL) begin
          if (seqCnt == SEQ_BLUE) begin
            seqCnt  <= SEQ_RED;
            addrReg <= addrReg + 1'b1;
          end else begin
            seqCnt <= seqCnt + 1'b1;
          end
        end
        if (stb.rdMode == MODE_CBUF && seqCnt == SEQ_RED) seqCnt <= SEQ_GREEN;
      end
    end
  end

endmodule

// File: rtl/lutHostPort.sv
module lutHostPort
  import lutHostPkg::*;
#(
  parameter int         ADDR_W = 13,
  parameter int         CH_W   = 8,
  parameter logic [2:0] REV_ID = 3'd5
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic                ceN,
  input  logic                rdWr,
  input  logic [2:0]          modeSel,
  input  logic [CH_W-1:0]     busIn,
  output logic [CH_W-1:0]     busOut,
  output logic                busOe,
  output logic                qPush,
  output logic [ADDR_W-1:0]   qAddr,
  output logic [3*CH_W-1:0]   qColor,
  input  logic                qEmptyN,
  input  logic                qLevelN,
  input  logic                qFullN,
  output logic [ADDR_W-1:0]   lutRdAddr,
  input  logic [3*CH_W-1:0]   lutRdData,
  output logic                prdActive,
  output logic [CH_W-1:0]     cmdReg,
  input  logic [CH_W-5:0]     boardRev
);

  hostStb_t stb;

  lutHostCtrl ctrlI (
    .clk     (clk),
    .rstN    (rstN),
    .ceN     (ceN),
    .rdWr    (rdWr),
    .modeSel (modeSel),
    .stb     (stb),
    .busOe   (busOe)
  );

  lutHostData #(
    .ADDR_W (ADDR_W),
    .CH_W   (CH_W),
    .REV_ID (REV_ID)
  ) dataI (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .busIn     (busIn),
    .qEmptyN   (qEmptyN),
    .qLevelN   (qLevelN),
    .qFullN    (qFullN),
    .lutRdData (lutRdData),
    .boardRev  (boardRev),
    .busOut    (busOut),
    .qPush     (qPush),
    .qAddr     (qAddr),
    .qColor    (qColor),
    .addrReg   (lutRdAddr),
    .prdActive (prdActive),
    .cmdReg    (cmdReg)
  );

endmodule

// File: rtl/lutHostChk.sv
module lutHostChk #(
  parameter int ADDR_W = 13,
  parameter int CH_W   = 8
)(
  input logic              clk,
  input logic              rstN,
  input logic              ceN,
  input logic              rdWr,
  input logic [2:0]        modeSel,
  input logic [CH_W-1:0]   busOut,
  input logic              busOe,
  input logic              qPush,
  input logic [ADDR_W-1:0] qAddr,
  input logic [ADDR_W-1:0] lutRdAddr,
  input logic              prdActive,
  input logic [CH_W-1:0]   cmdReg
);

  localparam int HI_W = ADDR_W - CH_W;

  AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    qPush |=> !qPush); // R1

  AST_PUSH_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    qPush |-> $past(!ceN && !rdWr && modeSel == 3'd2)); // R4

  AST_PUSH_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    qPush |-> lutRdAddr == ADDR_W'(qAddr + 1'b1)); // R4

  AST_HI_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ceN, 2) && $past(!ceN) && $past(rdWr) && $past(modeSel) == 3'd1)
      |-> busOut[CH_W-1:HI_W] == '0); // R2

  AST_BAD_WR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ceN, 2) && $past(!ceN) && !$past(rdWr) && $past(modeSel[2])
      && $past(modeSel) != 3'd7)
      |-> ($stable(cmdReg) && $stable(lutRdAddr) && $stable(prdActive))); // R10

  AST_PRD_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(prdActive) |-> $past(!ceN && !rdWr && modeSel == 3'd7)); // R11

  AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ceN |=> !busOe); // R12

endmodule

bind lutHostPort lutHostChk #(.ADDR_W(ADDR_W), .CH_W(CH_W)) chkI (.*);

// File: tb/lutHostPort_tb.sv
module lutHostPort_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        ceN;
  logic        rdWr;
  logic [2:0]  modeSel;
  logic [7:0]  busIn;
  logic [7:0]  busOut;
  logic        busOe;
  logic        qPush;
  logic [12:0] qAddr;
  logic [23:0] qColor;
  logic        qEmptyN;
  logic        qLevelN;
  logic        qFullN;
  logic [12:0] lutRdAddr;
  logic [23:0] lutRdData;
  logic        prdActive;
  logic [7:0]  cmdReg;
  logic [3:0]  boardRev;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  // lookup model: red/green/blue bytes derived arithmetically from the address
  function automatic logic [23:0] palModel(input logic [12:0] a);
    logic [7:0] r, g, b;
    r = 8'(a * 3 + 1);
    g = 8'(a * 5 + 2);
    b = 8'(a * 11 + 9);
    return {b, g, r};
  endfunction

  assign lutRdData = palModel(lutRdAddr);

  lutHostPort dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one access: chip enable low for one cycle, then high; returns at the
  // falling clock edge right after the access edge
  task automatic acc(input logic rw, input logic [2:0] m, input logic [7:0] d);
    @(negedge clk);
    ceN = 1'b0; rdWr = rw; modeSel = m; busIn = d;
    @(negedge clk);
    ceN = 1'b1;
  endtask

  task automatic setAddr(input logic [12:0] a);
    acc(1'b0, 3'd0, a[7:0]);
    acc(1'b0, 3'd1, {3'b111, a[12:8]});
  endtask

  task automatic readStatCnt(input logic [1:0] exp, input string req);
    acc(1'b1, 3'd4, 8'h00);
    check(req, 32'(busOut[1:0]), 32'(exp));
  endtask

  initial begin
    logic [12:0] a;
    logic [7:0]  r, g, b;
    rstN = 1'b0; ceN = 1'b1; rdWr = 1'b0; modeSel = 3'd0; busIn = 8'h00;
    qEmptyN = 1'b0; qLevelN = 1'b1; qFullN = 1'b1; boardRev = 4'h0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R12 reset state
    check("R12 reset busOut", 32'(busOut), 0);
    check("R12 reset busOe", 32'(busOe), 0);
    check("R12 reset qPush", 32'(qPush), 0);
    check("R12 reset prdActive", 32'(prdActive), 0);
    check("R12 reset cmdReg", 32'(cmdReg), 0);
    check("R12 reset address", 32'(lutRdAddr), 0);

    // R7 status layout over all flag combinations
    for (int f = 0; f < 8; f++) begin
      qEmptyN = f[0]; qLevelN = f[1]; qFullN = f[2];
      acc(1'b1, 3'd4, 8'h00);
      check("R7 status", 32'(busOut), 32'(f << 2));
    end

    // R12 drive enable and hold
    check("R12 busOe after read", 32'(busOe), 1);
    @(negedge clk);
    check("R12 busOe after ce high", 32'(busOe), 0);
    check("R12 busOut held", 32'(busOut), 32'(7 << 2));

    // R2 address registers
    for (int i = 0; i < 16; i++) begin
      a = 13'(i * 523 + 7);
      setAddr(a);
      check("R2 address", 32'(lutRdAddr), 32'(a));
      acc(1'b1, 3'd0, 8'h00);
      check("R2 read low", 32'(busOut), 32'(a[7:0]));
      acc(1'b1, 3'd1, 8'h00);
      check("R2 read high", 32'(busOut), 32'(a[12:8]));
    end

    // R4 / R3 palette writes with address wrap
    setAddr(13'h1FFE);
    for (int k = 0; k < 4; k++) begin
      r = 8'(k * 17 + 3); g = 8'(k * 29 + 100); b = 8'(k * 41 + 200);
      acc(1'b0, 3'd2, r);
      readStatCnt(2'd1, "R3 count after red");
      acc(1'b0, 3'd2, g);
      readStatCnt(2'd2, "R3 count after green");
      check("R4 no push before blue", 32'(qPush), 0);
      acc(1'b0, 3'd2, b);
      check("R4 push", 32'(qPush), 1);
      check("R4 push address", 32'(qAddr), 32'(13'(13'h1FFE + k)));
      check("R4 push colour", 32'(qColor), 32'({b, g, r}));
      @(negedge clk);
      check("R4 push single cycle", 32'(qPush), 0);
      readStatCnt(2'd0, "R4 count cleared");
    end
    check("R4 address wrapped", 32'(lutRdAddr), 2);

    // R3 address writes clear the count
    acc(1'b0, 3'd2, 8'h44);
    acc(1'b0, 3'd1, 8'h00);
    readStatCnt(2'd0, "R3 cleared by high write");
    acc(1'b0, 3'd2, 8'h44);
    acc(1'b0, 3'd2, 8'h45);
    acc(1'b0, 3'd0, 8'h10);
    readStatCnt(2'd0, "R3 cleared by low write");

    // R1 chip enable held low: one access only
    @(negedge clk);
    ceN = 1'b0; rdWr = 1'b0; modeSel = 3'd2; busIn = 8'h77;
    repeat (4) @(negedge clk);
    modeSel = 3'd0;
    @(negedge clk);
    ceN = 1'b1;
    readStatCnt(2'd1, "R1 single access per edge");
    check("R1 address untouched", 32'(lutRdAddr), 32'h010);

    // R6 colour buffer recovery
    setAddr(13'h0040);
    acc(1'b0, 3'd2, 8'hA5);
    acc(1'b0, 3'd2, 8'h3C);
    acc(1'b0, 3'd0, 8'h40);
    acc(1'b1, 3'd5, 8'h00);
    check("R6 red buffer", 32'(busOut), 32'hA5);
    readStatCnt(2'd1, "R6 count after red buffer");
    acc(1'b1, 3'd5, 8'h00);
    check("R6 green buffer", 32'(busOut), 32'h3C);
    readStatCnt(2'd1, "R6 count after green buffer");
    acc(1'b0, 3'd0, 8'h40);
    acc(1'b0, 3'd2, 8'h11);
    acc(1'b0, 3'd2, 8'h22);
    acc(1'b1, 3'd5, 8'h00);
    check("R6 invalid buffer read", 32'(busOut), 0);
    readStatCnt(2'd2, "R6 count kept at 2");
    check("R6 no push", 32'(qPush), 0);

    // R11 / R5 palette reads
    acc(1'b0, 3'd7, 8'h00);
    check("R11 read window set", 32'(prdActive), 1);
    setAddr(13'h1FFD);
    for (int j = 0; j < 6; j++) begin
      a = 13'(13'h1FFD + j);
      acc(1'b1, 3'd2, 8'h00);
      check("R5 red read", 32'(busOut), 32'(palModel(a)[7:0]));
      acc(1'b1, 3'd2, 8'h00);
      check("R5 green read", 32'(busOut), 32'(palModel(a)[15:8]));
      acc(1'b1, 3'd2, 8'h00);
      check("R5 blue read", 32'(busOut), 32'(palModel(a)[23:16]));
      check("R5 address step", 32'(lutRdAddr), 32'(13'(a + 1)));
    end
    acc(1'b1, 3'd7, 8'h00);
    check("R11 read window cleared", 32'(prdActive), 0);
    check("R11 read returns zero", 32'(busOut), 0);

    // R9 command register
    for (int v = 0; v < 6; v++) begin
      b = 8'(v * 51 + 15);
      acc(1'b0, 3'd3, b);
      check("R9 cmdReg", 32'(cmdReg), 32'(b));
      acc(1'b1, 3'd3, 8'h00);
      check("R9 command read", 32'(busOut), 32'(b));
    end

    // R10 invalid writes
    acc(1'b0, 3'd3, 8'h3C);
    setAddr(13'h0123);
    acc(1'b0, 3'd2, 8'h99);
    for (int m = 4; m < 7; m++) begin
      acc(1'b0, 3'(m), 8'hFF);
      check("R10 cmd kept", 32'(cmdReg), 32'h3C);
      check("R10 address kept", 32'(lutRdAddr), 32'h0123);
      check("R10 flag kept", 32'(prdActive), 0);
      check("R10 no push", 32'(qPush), 0);
    end
    readStatCnt(2'd1, "R10 count kept");
    acc(1'b0, 3'd0, 8'h23);
    acc(1'b1, 3'd5, 8'h00);
    check("R10 red buffer kept", 32'(busOut), 32'h99);

    // R8 revision register
    for (int br = 0; br < 16; br++) begin
      boardRev = 4'(br);
      acc(1'b1, 3'd6, 8'h00);
      check("R8 revision", 32'(busOut), 32'((br << 4) | 5));
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule